// File: doc/BRIEF.md
# Handshake Bus Protocol Monitor

This block sits beside a simple synchronous parallel bus and only listens to it. The bus has an address, a data bus, a direction line (high for read, low for write), a select strobe and a ready line. The monitor follows each transfer from the edge where select is first seen high to the edge where ready is seen high. It checks that the master holds its request steady while it waits, that the target answers within a bounded number of cycles, and that select is released after each transfer. It reports every completed transfer as a one-cycle record on a log output.

All outputs are registered. A result that belongs to the rising edge at which the inputs were sampled is visible from just after that edge until the next one. Every error output is a one-cycle pulse. A sticky flag records that at least one error has occurred since reset.

Top module: `bus_hs_monitor`

## Requirements
- R1: A read (select high, direction high) completes at the first sampled edge with ready high. For one cycle after that edge, `log_valid_o` is 1, `log_read_o` is 1, and `log_addr_o` and `log_data_o` hold the address and the data bus as sampled on that edge.
- R2: A write (select high, direction low) completes in the same way. Its record has `log_read_o` 0 and carries the write data.
- R3: If ready is already high on the edge where select is first sampled high, the transfer completes on that edge (zero wait states).
- R4: While a transfer waits for ready, a change of address or direction raises `err_stable_o` for one cycle. So does a change of the data bus during a write, or select dropping early. No record is logged for that transfer. During a read, changes on the data bus before ready are not errors.
- R5: The first edge with select high counts as edge 1. If ready has not been seen by edge TIMEOUT, `err_timeout_o` pulses after that edge. Ready on edge TIMEOUT still completes normally.
- R6: Ready sampled high while select is sampled low raises `err_spurious_o` for one cycle.
- R7: Select must be sampled low on the edge after a completing edge. Otherwise `err_deassert_o` pulses for one cycle.
- R8: After a stability, timeout or deassert error, the monitor ignores the bus until select is sampled low. Ready seen during that time produces no record.
- R9: `err_any_o` becomes 1 together with the first error pulse and stays 1 until reset.
- R10: Asserting `rst_ni` low returns the monitor to idle and clears every output, including `err_any_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Observed address bus |
| bus_data_i | input | DATA_W | Observed data bus |
| bus_rd_i | input | 1 | Observed direction, 1 = read, 0 = write |
| bus_sel_i | input | 1 | Observed select strobe |
| bus_rdy_i | input | 1 | Observed ready line |
| log_valid_o | output | 1 | One-cycle pulse per completed transfer |
| log_read_o | output | 1 | Direction of the logged transfer |
| log_addr_o | output | ADDR_W | Address of the logged transfer |
| log_data_o | output | DATA_W | Data of the logged transfer |
| err_stable_o | output | 1 | Request changed while pending |
| err_timeout_o | output | 1 | Ready not seen in time |
| err_spurious_o | output | 1 | Ready without select |
| err_deassert_o | output | 1 | Select not released after completion |
| err_any_o | output | 1 | Sticky: any error since reset |

## Verification
The assertions assume that the bus inputs are known, 0 or 1, on every sampled edge after reset. They also assume that a correct master puts one idle edge, with select low, between transfers. The bench changes inputs only at the falling clock edge. It always returns select and ready to 0 after each scenario. It produces each violation on purpose, one at a time, so that only one class of error can fire in any cycle it checks.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for select
    ST_PEND = 2'd1,  // select seen, waiting for ready
    ST_DONE = 2'd2,  // completed, select must drop next edge
    ST_HOLD = 2'd3   // transfer abandoned, wait for select low
  } mon_state_e;
endpackage

// File: rtl/bus_mon_capture.sv
module bus_mon_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic              diff_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
    end else if (load_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
      rd_q   <= rd_i;
    end
  end

  // write data only matters for writes
  always_comb begin
    diff_o = (addr_i != addr_q) || (rd_i != rd_q);
    if (!rd_q && (data_i != data_q)) diff_o = 1'b1;
  end
endmodule

// File: rtl/bus_mon_timer.sv
module bus_mon_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic step_i,
  output logic last_o
);
  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(1);
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  // the coming edge is edge number TIMEOUT
  assign last_o = (cnt_q == LAST_CNT);
endmodule

// File: rtl/bus_mon_fsm.sv
module bus_mon_fsm
  import bus_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic rdy_i,
  input  logic diff_i,
  input  logic last_i,
  output logic load_o,
  output logic start_o,
  output logic step_o,
  output logic done_o,
  output logic stable_o,
  output logic timeout_o,
  output logic deassert_o
);
  mon_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    start_o    = 1'b0;
    step_o     = 1'b0;
    done_o     = 1'b0;
    stable_o   = 1'b0;
    timeout_o  = 1'b0;
    deassert_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sel_i) begin
          load_o = 1'b1;
          if (rdy_i) begin
            done_o  = 1'b1;
            state_d = ST_DONE;
          end else begin
            start_o = 1'b1;
            state_d = ST_PEND;
          end
        end
      end
      ST_PEND: begin
        if (!sel_i) begin
          stable_o = 1'b1;
          state_d  = ST_IDLE;
        end else if (diff_i) begin
          stable_o = 1'b1;
          state_d  = ST_HOLD;
        end else if (rdy_i) begin
          done_o  = 1'b1;
          state_d = ST_DONE;
        end else if (last_i) begin
          timeout_o = 1'b1;
          state_d   = ST_HOLD;
        end else begin
          step_o = 1'b1;
        end
      end
      ST_DONE: begin
        if (sel_i) begin
          deassert_o = 1'b1;
          state_d    = ST_HOLD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!sel_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/bus_hs_monitor.sv
module bus_hs_monitor #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_rd_i,
  input  logic              bus_sel_i,
  input  logic              bus_rdy_i,
  output logic              log_valid_o,
  output logic              log_read_o,
  output logic [ADDR_W-1:0] log_addr_o,
  output logic [DATA_W-1:0] log_data_o,
  output logic              err_stable_o,
  output logic              err_timeout_o,
  output logic              err_spurious_o,
  output logic              err_deassert_o,
  output logic              err_any_o
);
  logic load, start, step, diff, last;
  logic ev_done, ev_stable, ev_timeout, ev_deassert, ev_spurious, ev_any;

  bus_mon_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (bus_addr_i),
    .data_i (bus_data_i),
    .rd_i   (bus_rd_i),
    .diff_o (diff)
  );

  bus_mon_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .step_i  (step),
    .last_o  (last)
  );

  bus_mon_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (bus_sel_i),
    .rdy_i      (bus_rdy_i),
    .diff_i     (diff),
    .last_i     (last),
    .load_o     (load),
    .start_o    (start),
    .step_o     (step),
    .done_o     (ev_done),
    .stable_o   (ev_stable),
    .timeout_o  (ev_timeout),
    .deassert_o (ev_deassert)
  );

  assign ev_spurious = bus_rdy_i && !bus_sel_i;
  assign ev_any      = ev_stable | ev_timeout | ev_spurious | ev_deassert;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      log_valid_o    <= 1'b0;
      log_read_o     <= 1'b0;
      log_addr_o     <= '0;
      log_data_o     <= '0;
      err_stable_o   <= 1'b0;
      err_timeout_o  <= 1'b0;
      err_spurious_o <= 1'b0;
      err_deassert_o <= 1'b0;
      err_any_o      <= 1'b0;
    end else begin
      log_valid_o    <= ev_done;
      err_stable_o   <= ev_stable;
      err_timeout_o  <= ev_timeout;
      err_spurious_o <= ev_spurious;
      err_deassert_o <= ev_deassert;
      err_any_o      <= err_any_o | ev_any;
      if (ev_done) begin
        log_read_o <= bus_rd_i;
        log_addr_o <= bus_addr_i;
        log_data_o <= bus_data_i;
      end
    end
  end
endmodule

// File: rtl/bus_hs_monitor_checker.sv
module bus_hs_monitor_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_sel_i,
  input logic bus_rdy_i,
  input logic log_valid_o,
  input logic err_stable_o,
  input logic err_timeout_o,
  input logic err_spurious_o,
  input logic err_deassert_o,
  input logic err_any_o
);
  assert_log_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_valid_o |=> !log_valid_o);

  assert_no_log_on_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(log_valid_o && err_stable_o));

  assert_stable_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_stable_o |=> !err_stable_o);

  assert_timeout_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_timeout_o |=> !err_timeout_o);

  assert_spurious_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_spurious_o |-> $past(bus_rdy_i) && !$past(bus_sel_i));

  assert_deassert_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_deassert_o |-> $past(bus_sel_i));

  assert_abort_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_stable_o, err_timeout_o, err_deassert_o}));

  assert_any_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any_o |=> err_any_o);

  assert_any_covers_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_stable_o || err_timeout_o || err_spurious_o || err_deassert_o) |-> err_any_o);
endmodule

bind bus_hs_monitor bus_hs_monitor_checker u_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bus_sel_i      (bus_sel_i),
  .bus_rdy_i      (bus_rdy_i),
  .log_valid_o    (log_valid_o),
  .err_stable_o   (err_stable_o),
  .err_timeout_o  (err_timeout_o),
  .err_spurious_o (err_spurious_o),
  .err_deassert_o (err_deassert_o),
  .err_any_o      (err_any_o)
);

// File: tb/bus_hs_monitor_bench.sv
`timescale 1ns/1ps
module bus_hs_monitor_bench;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int TIMEOUT = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_data = '0;
  logic              bus_rd = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_rdy = 1'b0;
  logic              log_valid, log_read;
  logic [ADDR_W-1:0] log_addr;
  logic [DATA_W-1:0] log_data;
  logic              err_stable, err_timeout, err_spurious, err_deassert, err_any;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_hs_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_bus_hs_monitor (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bus_addr_i     (bus_addr),
    .bus_data_i     (bus_data),
    .bus_rd_i       (bus_rd),
    .bus_sel_i      (bus_sel),
    .bus_rdy_i      (bus_rdy),
    .log_valid_o    (log_valid),
    .log_read_o     (log_read),
    .log_addr_o     (log_addr),
    .log_data_o     (log_data),
    .err_stable_o   (err_stable),
    .err_timeout_o  (err_timeout),
    .err_spurious_o (err_spurious),
    .err_deassert_o (err_deassert),
    .err_any_o      (err_any)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one rising edge; returns at the falling edge that follows it
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_quiet(input string req);
    check({req, " valid"},    log_valid,    0);
    check({req, " stable"},   err_stable,   0);
    check({req, " timeout"},  err_timeout,  0);
    check({req, " spurious"}, err_spurious, 0);
    check({req, " deassert"}, err_deassert, 0);
  endtask

  task automatic release_bus();
    bus_sel = 1'b0;
    bus_rdy = 1'b0;
    tick();
  endtask

  task automatic do_xfer(input bit rd, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input int wt, input string req);
    bus_sel = 1'b1; bus_rd = rd; bus_addr = a;
    bus_data = rd ? DATA_W'($urandom) : d;
    for (int i = 0; i < wt; i++) begin
      bus_rdy = 1'b0;
      tick();
      check({req, " no log while waiting"}, log_valid, 0);
      check("R4 read data may change", err_stable, 0);
      if (rd) bus_data = DATA_W'($urandom);
    end
    bus_rdy = 1'b1;
    bus_data = d;
    tick();
    check({req, " valid"}, log_valid, 1);
    check({req, " dir"},   log_read,  64'(rd));
    check({req, " addr"},  log_addr,  64'(a));
    check({req, " data"},  log_data,  64'(d));
    check({req, " no timeout"}, err_timeout, 0);
    release_bus();
    check_quiet({req, " after release"});
  endtask

  task automatic test_reset();
    check("R10 valid",  log_valid, 0);
    check("R10 any",    err_any,   0);
    check("R10 addr",   log_addr,  0);
    check_quiet("R10");
  endtask

  task automatic test_legal();
    do_xfer(1'b1, 16'h1234, 32'hCAFE_0001, 3, "R1 read");
    do_xfer(1'b0, 16'h00F0, 32'h5555_AAAA, 2, "R2 write");
    do_xfer(1'b1, 16'hBEEF, 32'h0BAD_F00D, 0, "R3 read zero wait");
    do_xfer(1'b0, 16'h7777, 32'h1357_9BDF, 0, "R3 write zero wait");
    for (int k = 0; k < 6; k++)
      do_xfer(k[0], ADDR_W'($urandom), DATA_W'($urandom), int'($urandom_range(0, TIMEOUT - 1)), "R1 random");
    do_xfer(1'b1, 16'h0F0F, 32'h1111_2222, TIMEOUT - 1, "R5 ready on last edge");
    check("R9 no error yet", err_any, 0);
  endtask

  task automatic test_stable_addr();
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 16'h4000; bus_rdy = 1'b0;
    tick();
    bus_addr = 16'h4004;
    tick();
    check("R4 addr change", err_stable, 1);
    check("R4 no log", log_valid, 0);
    bus_rdy = 1'b1;
    tick();
    check("R4 pulse one cycle", err_stable, 0);
    check("R8 ignored ready", log_valid, 0);
    release_bus();
    check_quiet("R4 after release");
  endtask

  task automatic test_stable_wdata();
    bus_sel = 1'b1; bus_rd = 1'b0; bus_addr = 16'h2000; bus_data = 32'hAAAA_0000; bus_rdy = 1'b0;
    tick();
    tick();
    check("R4 still fine", err_stable, 0);
    bus_data = 32'hAAAA_0001;
    tick();
    check("R4 write data change", err_stable, 1);
    release_bus();
    check("R4 pulse one cycle", err_stable, 0);
  endtask

  task automatic test_stable_dir();
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 16'h3000; bus_rdy = 1'b0;
    tick();
    bus_rd = 1'b0;
    tick();
    check("R4 direction change", err_stable, 1);
    release_bus();
  endtask

  task automatic test_timeout();
    bus_sel = 1'b1; bus_rd = 1'b0; bus_addr = 16'h0100; bus_data = 32'h0; bus_rdy = 1'b0;
    for (int e = 1; e < TIMEOUT; e++) begin
      tick();
      check("R5 before limit", err_timeout, 0);
    end
    tick();
    check("R5 timeout edge", err_timeout, 1);
    check("R5 no log", log_valid, 0);
    bus_rdy = 1'b1;
    tick();
    check("R5 pulse one cycle", err_timeout, 0);
    check("R8 late ready ignored", log_valid, 0);
    release_bus();
    check_quiet("R5 after release");
  endtask

  task automatic test_spurious();
    bus_sel = 1'b0; bus_rdy = 1'b1;
    tick();
    check("R6 spurious", err_spurious, 1);
    check("R6 no log", log_valid, 0);
    bus_rdy = 1'b0;
    tick();
    check("R6 pulse one cycle", err_spurious, 0);
  endtask

  task automatic test_deassert();
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 16'h0808; bus_data = 32'h8080_8080; bus_rdy = 1'b1;
    tick();
    check("R7 completed", log_valid, 1);
    bus_rdy = 1'b0;
    tick();
    check("R7 missing deassert", err_deassert, 1);
    bus_rdy = 1'b1;
    tick();
    check("R7 pulse one cycle", err_deassert, 0);
    check("R8 held select no log", log_valid, 0);
    release_bus();
    check_quiet("R7 after release");
  endtask

  task automatic test_sticky_and_reset();
    check("R9 sticky set", err_any, 1);
    tick();
    check("R9 sticky holds", err_any, 1);
    rst_n = 1'b0;
    #1;
    check("R10 async clear any", err_any, 0);
    tick();
    rst_n = 1'b1;
    tick();
    test_reset();
    do_xfer(1'b0, 16'h0042, 32'h4242_4242, 1, "R2 after reset");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    test_reset();
    rst_n = 1'b1;
    tick();
    test_reset();
    test_legal();
    test_stable_addr();
    test_stable_wdata();
    test_stable_dir();
    test_timeout();
    test_spurious();
    test_deassert();
    test_sticky_and_reset();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule